// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block runs one DMA channel by walking a linked list of command descriptors in a word-addressed memory. Each descriptor is a short record: a pointer to the next descriptor, a command word, a buffer address and up to six programming words for the attached peripheral. For each descriptor the engine first streams the programming words to the peripheral. It then moves data between the peripheral and memory in the direction the command selects, and holds until the device reports ready or end of transfer if the command asks for it. Finally it performs the semaphore and interrupt actions.

Software points the channel at the first descriptor by loading the descriptor pointer, then writes an increment to the semaphore. While the channel is idle, a semaphore write that leaves a non-zero count starts it. The engine continues along the chain only while the command carries the chain flag and the semaphore stays above zero. A completion flag, cleared by a write-one pulse, signals that a descriptor asking for an interrupt has finished. A channel reset pulse forces the engine back to idle.

Descriptor layout, as word offsets from the descriptor address: 0 next pointer, 1 command word, 2 buffer address, 3 to 8 programming words. Transfer counts are in memory words (beats).

Top module: `dmac_chain_engine`

## Requirements
- R1: After reset, busy, sema_cnt, cmplt_irq, dev_lock, mem_rd, mem_wr, pio_valid, dev_rd and dev_wvalid are all 0.
- R2: A semaphore write that leaves the count non-zero while idle starts the engine at the loaded pointer. A write of 0 to a zero semaphore does not start it. Descriptor words are read at offsets 0 (next), 1 (command) and 2 (buffer).
- R3: Command bits [15:12] give the number of programming words, with values above 6 treated as 6. The words from offsets 3 onward are presented on pio_data with pio_valid on consecutive cycles, with pio_index counting up from 0. All of them are presented before the first data beat of that descriptor.
- R4: Transfer type 1 (bits [1:0]) moves count (bits [31:16]) beats from the peripheral to memory. Each beat strobes dev_rd, and the beats are written to buffer, buffer+1, and onward in order.
- R5: Transfer type 2 reads count beats from buffer upward and delivers them in order on dev_wdata with dev_wvalid.
- R6: Transfer types 0 and 3, or a count of 0, produce no data beat: no mem_wr, no dev_rd, no dev_wvalid.
- R7: Command bit 5 holds completion until dev_ready is 1. Command bit 7 holds completion until dev_end is 1.
- R8: Command bit 6 lowers the semaphore by one when the descriptor completes, never below zero. A software semaphore write adds its value, even while the engine is busy.
- R9: After a descriptor completes, the engine fetches the next-pointer descriptor only if command bit 2 is set and the semaphore is non-zero. Otherwise it returns to idle.
- R10: Command bit 3 sets cmplt_irq when the descriptor completes. A cmplt_clr pulse clears it, and a set in the same cycle as a clear wins.
- R11: Command bit 4 raises dev_lock from that descriptor until the engine returns to idle. It is 0 whenever the engine is idle.
- R12: A chan_rst pulse returns the engine to idle, clears the semaphore and drops dev_lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_we | input | 1 | Load the descriptor pointer |
| ptr_addr | input | AW | First descriptor address |
| sema_we | input | 1 | Add sema_inc to the semaphore |
| sema_inc | input | SW | Semaphore increment |
| cmplt_clr | input | 1 | Write-one clear of the completion flag |
| chan_rst | input | 1 | Channel reset pulse |
| busy | output | 1 | Engine not idle |
| sema_cnt | output | SW | Semaphore value |
| cmplt_irq | output | 1 | Completion flag |
| mem_rd | output | 1 | Memory read; data returns next cycle |
| mem_wr | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| pio_valid | output | 1 | Programming word strobe |
| pio_index | output | 3 | Programming word number |
| pio_data | output | 32 | Programming word |
| dev_rd | output | 1 | Take one beat from the peripheral |
| dev_rdata | input | 32 | Peripheral beat, sampled with dev_rd |
| dev_wvalid | output | 1 | Beat delivered to the peripheral |
| dev_wdata | output | 32 | Beat for the peripheral |
| dev_ready | input | 1 | Device ready |
| dev_end | input | 1 | Device end of transfer |
| dev_lock | output | 1 | Device held by the channel |

## Verification
A corrupted fetch index or return tag shows up within one descriptor as programming words out of order, or as a command word driving the wrong transfer type. Either appears at the peripheral port within a few cycles of the fetch. A wrong semaphore or chain decision shows up at the end of the descriptor, either as an extra descriptor's programming words or as busy dropping early. A stuck wait shows up as busy never falling, and a wrong beat counter shows up as a beat-count mismatch at the memory or peripheral side.

// File: rtl/dmac_pkg.sv
// Shared definitions for the descriptor DMA channel.
// Assumes 32-bit memory words and the fixed descriptor layout of the brief.
package dmac_pkg;
    localparam int DATA_W   = 32;
    localparam int PIO_MAX  = 6;
    localparam int OFS_PIO  = 3;
    localparam logic [3:0] TAG_DATA = 4'd15;

    typedef enum logic [1:0] {
        XT_NONE    = 2'd0,
        XT_TOMEM   = 2'd1,
        XT_FROMMEM = 2'd2,
        XT_SENSE   = 2'd3
    } xfer_t;

    typedef struct packed {
        logic [15:0] count;
        logic [3:0]  npio;
        logic [1:0]  rsv;
        logic        flush_term;
        logic        halt_term;
        logic        wait_end;
        logic        dec_sema;
        logic        wait_ready;
        logic        lock;
        logic        irq;
        logic        chain;
        xfer_t       xt;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_PIO, S_GAP, S_XFER, S_WAIT, S_DONE
    } st_t;
endpackage

// File: rtl/dmac_sema.sv
// Channel semaphore: software adds, descriptor completion subtracts one.
// Assumes a single decrement per cycle; the count never drops below zero.
module dmac_sema #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_rst,
    input  logic          inc_we,
    input  logic [SW-1:0] inc,
    input  logic          dec,
    output logic [SW-1:0] sema,
    output logic          start_req,
    output logic          next_zero
);
    logic [SW-1:0] sum;
    logic [SW-1:0] nxt;

    // Value after this cycle's add and optional decrement.
    always_comb begin
        sum = sema + (inc_we ? inc : '0);
        nxt = sum - ((dec && (sum != '0)) ? SW'(1) : '0);
    end

    assign start_req = inc_we && (sum != '0);
    assign next_zero = (nxt == '0);

    // Semaphore register.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) sema <= '0;
        else                    sema <= nxt;
    end

    assert_sema_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sema == '0 && !inc_we && !chan_rst) |=> (sema == '0));
    assert_sema_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_we && !chan_rst) |=> (sema == $past(sema) || sema == $past(sema) - SW'(1)));
    assert_sema_rst_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (sema == '0));
endmodule

// File: rtl/dmac_flag.sv
// Completion flag with write-one clear; a set in the same cycle wins.
module dmac_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (set)  flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    assert_flag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/dmac_seq.sv
// Descriptor sequencer: fetches descriptor words, streams programming
// words, moves data beats, waits on the device and closes each descriptor.
// Assumes memory returns read data exactly one cycle after mem_rd and that
// the peripheral accepts or supplies one beat per cycle without stalling.
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic              ptr_we,
    input  logic [AW-1:0]     ptr_addr,
    input  logic              start_req,
    input  logic              sema_next_zero,
    output logic              busy,
    output logic              done_dec,
    output logic              done_irq,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              pio_valid,
    output logic [2:0]        pio_index,
    output logic [DATA_W-1:0] pio_data,
    output logic              dev_rd,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_wvalid,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic              dev_ready,
    input  logic              dev_end,
    output logic              dev_lock
);
    st_t           st;
    logic [3:0]    idx;
    logic [15:0]   cnt;
    logic [AW-1:0] ptr_reg, desc_ptr, nxt_f, buf_f;
    cmd_t          cmd_f;
    logic          rv_q, lock_q;
    logic [3:0]    rtag_q, issue_tag;
    logic [3:0]    npio_eff;
    logic          has_xfer, wait_ok;
    logic          unused_cmd_bits;

    assign unused_cmd_bits = ^{cmd_f.rsv, cmd_f.halt_term, cmd_f.flush_term};

    // Decoded controls of the current command.
    always_comb begin
        npio_eff = (cmd_f.npio > 4'(PIO_MAX)) ? 4'(PIO_MAX) : cmd_f.npio;
        has_xfer = (cmd_f.xt == XT_TOMEM || cmd_f.xt == XT_FROMMEM) && (cmd_f.count != '0);
        wait_ok  = (!cmd_f.wait_ready || dev_ready) && (!cmd_f.wait_end || dev_end);
    end

    // Memory request generation and return tagging.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        issue_tag = '0;
        case (st)
            S_FETCH: begin
                mem_rd    = 1'b1;
                mem_addr  = desc_ptr + AW'(idx);
                issue_tag = idx;
            end
            S_PIO: begin
                mem_rd    = 1'b1;
                mem_addr  = desc_ptr + AW'(idx) + AW'(OFS_PIO);
                issue_tag = idx + 4'(OFS_PIO);
            end
            S_XFER: begin
                mem_addr = buf_f + AW'(cnt);
                if (cmd_f.xt == XT_FROMMEM) begin
                    mem_rd    = 1'b1;
                    issue_tag = TAG_DATA;
                end else begin
                    mem_wr = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign mem_wdata  = dev_rdata;
    assign dev_rd     = mem_wr;
    assign pio_valid  = rv_q && (rtag_q >= 4'(OFS_PIO)) && (rtag_q < 4'(OFS_PIO + PIO_MAX));
    assign pio_index  = 3'(rtag_q - 4'(OFS_PIO));
    assign pio_data   = mem_rdata;
    assign dev_wvalid = rv_q && (rtag_q == TAG_DATA);
    assign dev_wdata  = mem_rdata;
    assign busy       = (st != S_IDLE);
    assign dev_lock   = lock_q;
    assign done_dec   = (st == S_DONE) && cmd_f.dec_sema;
    assign done_irq   = (st == S_DONE) && cmd_f.irq;

    // Software-loaded first-descriptor pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_reg <= '0;
        else if (ptr_we) ptr_reg <= ptr_addr;
    end

    // Channel state machine and descriptor field capture.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            st       <= S_IDLE;
            idx      <= '0;
            cnt      <= '0;
            rv_q     <= 1'b0;
            rtag_q   <= '0;
            lock_q   <= 1'b0;
            desc_ptr <= '0;
            nxt_f    <= '0;
            buf_f    <= '0;
            cmd_f    <= '0;
        end else begin
            rv_q   <= mem_rd;
            rtag_q <= issue_tag;
            if (rv_q) begin
                case (rtag_q)
                    4'd0:    nxt_f <= mem_rdata[AW-1:0];
                    4'd1:    cmd_f <= cmd_t'(mem_rdata);
                    4'd2:    buf_f <= mem_rdata[AW-1:0];
                    default: ;
                endcase
            end
            case (st)
                S_IDLE: if (start_req) begin
                    desc_ptr <= ptr_reg;
                    idx      <= '0;
                    st       <= S_FETCH;
                end
                S_FETCH: begin
                    if (idx == 4'd2) begin
                        idx <= '0;
                        st  <= S_DECODE;
                    end else idx <= idx + 4'd1;
                end
                S_DECODE: begin
                    if (cmd_f.lock) lock_q <= 1'b1;
                    st <= (npio_eff != '0) ? S_PIO : S_GAP;
                end
                S_PIO: begin
                    if (idx == npio_eff - 4'd1) begin
                        idx <= '0;
                        st  <= S_GAP;
                    end else idx <= idx + 4'd1;
                end
                S_GAP: begin
                    cnt <= '0;
                    st  <= has_xfer ? S_XFER : S_WAIT;
                end
                S_XFER: begin
                    if (cnt == cmd_f.count - 16'd1) st <= S_WAIT;
                    else                            cnt <= cnt + 16'd1;
                end
                S_WAIT: if (wait_ok) st <= S_DONE;
                S_DONE: begin
                    if (cmd_f.chain && !sema_next_zero) begin
                        desc_ptr <= nxt_f;
                        idx      <= '0;
                        st       <= S_FETCH;
                    end else begin
                        lock_q <= 1'b0;
                        st     <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assert_pio_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_valid && $past(pio_valid)) |-> (pio_index == $past(pio_index) + 3'd1));
    assert_pio_before_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pio_valid && (dev_wvalid || mem_wr)));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !dev_wvalid && !pio_valid));
    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WAIT && !wait_ok && !chan_rst) |=> busy);
    assert_lock_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dev_lock);
    assert_rst_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (!busy && !dev_lock));
endmodule

// File: rtl/dmac_chain_engine.sv
// Top of the descriptor DMA channel: sequencer, semaphore and completion flag.
// Assumes one channel and a dedicated memory port with one-cycle read latency.
module dmac_chain_engine #(
    parameter int AW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_we,
    input  logic [AW-1:0] ptr_addr,
    input  logic          sema_we,
    input  logic [SW-1:0] sema_inc,
    input  logic          cmplt_clr,
    input  logic          chan_rst,
    output logic          busy,
    output logic [SW-1:0] sema_cnt,
    output logic          cmplt_irq,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          pio_valid,
    output logic [2:0]    pio_index,
    output logic [31:0]   pio_data,
    output logic          dev_rd,
    input  logic [31:0]   dev_rdata,
    output logic          dev_wvalid,
    output logic [31:0]   dev_wdata,
    input  logic          dev_ready,
    input  logic          dev_end,
    output logic          dev_lock
);
    logic start_req, next_zero, done_dec, done_irq;

    dmac_sema #(.SW(SW)) u_sema (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
        .inc_we(sema_we), .inc(sema_inc), .dec(done_dec),
        .sema(sema_cnt), .start_req(start_req), .next_zero(next_zero)
    );

    dmac_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(done_irq), .clr(cmplt_clr), .flag(cmplt_irq)
    );

    dmac_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
        .ptr_we(ptr_we), .ptr_addr(ptr_addr),
        .start_req(start_req), .sema_next_zero(next_zero),
        .busy(busy), .done_dec(done_dec), .done_irq(done_irq),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pio_valid(pio_valid), .pio_index(pio_index), .pio_data(pio_data),
        .dev_rd(dev_rd), .dev_rdata(dev_rdata),
        .dev_wvalid(dev_wvalid), .dev_wdata(dev_wdata),
        .dev_ready(dev_ready), .dev_end(dev_end), .dev_lock(dev_lock)
    );
endmodule

// File: tb/sim_dmac_chain_engine.sv
module sim_dmac_chain_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ptr_we = 1'b0, sema_we = 1'b0, cmplt_clr = 1'b0, chan_rst = 1'b0;
    logic [AW-1:0] ptr_addr = '0;
    logic [SW-1:0] sema_inc = '0;
    logic busy, cmplt_irq, mem_rd, mem_wr, pio_valid, dev_rd, dev_wvalid, dev_lock;
    logic [SW-1:0] sema_cnt;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, pio_data, dev_wdata, dev_rdata;
    logic [31:0] mem_rdata = '0;
    logic [2:0] pio_index;
    logic dev_ready = 1'b1, dev_end = 1'b1;

    logic [31:0] mem [0:255];
    logic tb_we = 1'b0;
    logic [7:0] tb_wa = '0;
    logic [31:0] tb_wd = '0;
    logic [15:0] dev_beat = '0;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    logic mon_clr = 1'b0;
    int pio_n, w_n, wr_n, rd_n;
    logic data_seen, order_bad;
    logic [31:0] pio_log [0:7];
    logic [2:0]  pio_ix [0:7];
    int          pio_cyc [0:7];
    logic [31:0] wlog [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_chain_engine #(.AW(AW), .SW(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_addr(ptr_addr),
        .sema_we(sema_we), .sema_inc(sema_inc), .cmplt_clr(cmplt_clr), .chan_rst(chan_rst),
        .busy(busy), .sema_cnt(sema_cnt), .cmplt_irq(cmplt_irq),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pio_valid(pio_valid), .pio_index(pio_index), .pio_data(pio_data),
        .dev_rd(dev_rd), .dev_rdata(dev_rdata), .dev_wvalid(dev_wvalid), .dev_wdata(dev_wdata),
        .dev_ready(dev_ready), .dev_end(dev_end), .dev_lock(dev_lock)
    );

    // Memory model with one-cycle read latency and a bench write port.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (tb_we)  mem[tb_wa] <= tb_wd;
    end

    // Peripheral source: a running beat counter.
    always @(posedge clk) if (dev_rd) dev_beat <= dev_beat + 16'd1;
    assign dev_rdata = {16'hD0AA, dev_beat};

    // Port monitor, sampled on the falling edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            pio_n <= 0; w_n <= 0; wr_n <= 0; rd_n <= 0;
            data_seen <= 1'b0; order_bad <= 1'b0;
        end else begin
            if (pio_valid && pio_n < 8) begin
                pio_log[pio_n] <= pio_data;
                pio_ix[pio_n]  <= pio_index;
                pio_cyc[pio_n] <= cyc;
                pio_n <= pio_n + 1;
                if (data_seen || dev_wvalid || mem_wr) order_bad <= 1'b1;
            end
            if (dev_wvalid && w_n < 8) begin
                wlog[w_n] <= dev_wdata;
                w_n <= w_n + 1;
            end
            if (mem_wr) wr_n <= wr_n + 1;
            if (dev_rd) rd_n <= rd_n + 1;
            if (dev_wvalid || mem_wr) data_seen <= 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [31:0] d);
        tb_we = 1'b1; tb_wa = 8'(a); tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input int cnt, input int np, input bit wend,
            input bit dec, input bit wrdy, input bit lock, input bit irq, input bit chain, input int t);
        return {cnt[15:0], np[3:0], 4'b0, wend, dec, wrdy, lock, irq, chain, t[1:0]};
    endfunction

    task automatic put_desc(input int base, input int nxt, input logic [31:0] cmd,
            input int bufa, input logic [31:0] pbase);
        poke(base, 32'(nxt));
        poke(base + 1, cmd);
        poke(base + 2, 32'(bufa));
        for (int i = 0; i < 6; i++) poke(base + 3 + i, pbase + 32'(i));
    endtask

    task automatic mclr();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic start(input int p, input int inc);
        ptr_we = 1'b1; ptr_addr = AW'(p);
        @(negedge clk); ptr_we = 1'b0;
        sema_we = 1'b1; sema_inc = SW'(inc);
        @(negedge clk); sema_we = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int g = 0;
        while (busy && g < 5000) begin @(negedge clk); g++; end
        chk({req, " finishes"}, 32'(busy), 32'd0);
    endtask

    task automatic clear_irq();
        cmplt_clr = 1'b1;
        @(negedge clk); cmplt_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] beat0;
        int np, bufa, run;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 sema", 32'(sema_cnt), 0);
        chk("R1 irq", 32'(cmplt_irq), 0);
        chk("R1 lock", 32'(dev_lock), 0);
        chk("R1 strobes", 32'({mem_rd, mem_wr, pio_valid, dev_rd, dev_wvalid}), 0);
        for (int k = 0; k < 4; k++) poke(128 + k, 32'hC000_0000 + 32'(k));

        // R2: zero write to zero semaphore does not start
        put_desc(16, 0, mk_cmd(0, 1, 0, 1, 0, 0, 1, 0, 0), 128, 32'h7777_0000);
        start(16, 0);
        repeat (3) @(negedge clk);
        chk("R2 no start on zero", 32'(busy), 0);
        chk("R2 no pio on zero", 32'(pio_valid), 0);

        // Sweep: type x programming-word count x beat count (R2-R6, R8, R10)
        run = 0;
        for (int t = 0; t < 4; t++) begin
            for (int n = 0; n < 8; n++) begin
                for (int L = 0; L < 5; L++) begin
                    np = (n > 6) ? 6 : n;
                    bufa = (t == 1) ? 192 : 128;
                    put_desc(16, 0, mk_cmd(L, n, 0, 1, 0, 0, 1, 0, t), bufa,
                             32'h5000_0000 + 32'(run << 4));
                    mclr();
                    beat0 = dev_beat;
                    start(16, 1);
                    wait_idle("R2 sweep");
                    chk("R3 pio count", 32'(pio_n), 32'(np));
                    for (int i = 0; i < np; i++) begin
                        chk("R3 pio data", pio_log[i], 32'h5000_0000 + 32'(run << 4) + 32'(i));
                        chk("R3 pio index", 32'(pio_ix[i]), 32'(i));
                    end
                    if (np > 0) chk("R3 back to back", 32'(pio_cyc[np-1] - pio_cyc[0]), 32'(np - 1));
                    chk("R3 pio before data", 32'(order_bad), 0);
                    if (t == 1 && L > 0) begin
                        chk("R4 beats taken", 32'(rd_n), 32'(L));
                        chk("R4 beats written", 32'(wr_n), 32'(L));
                        for (int k = 0; k < L; k++)
                            chk("R4 memory data", mem[192 + k], {16'hD0AA, beat0 + 16'(k)});
                        chk("R4 no peripheral writes", 32'(w_n), 0);
                    end else if (t == 2 && L > 0) begin
                        chk("R5 beats delivered", 32'(w_n), 32'(L));
                        for (int k = 0; k < L; k++)
                            chk("R5 beat data", wlog[k], 32'hC000_0000 + 32'(k));
                        chk("R5 no memory writes", 32'(wr_n), 0);
                    end else begin
                        chk("R6 no data beats", 32'(w_n + wr_n + rd_n), 0);
                    end
                    chk("R8 decrement", 32'(sema_cnt), 0);
                    chk("R10 flag set", 32'(cmplt_irq), 1);
                    clear_irq();
                    chk("R10 flag cleared", 32'(cmplt_irq), 0);
                    run++;
                end
            end
        end

        // R7/R11/R8: wait for ready with lock, semaphore add while busy
        put_desc(48, 0, mk_cmd(0, 0, 0, 1, 1, 1, 0, 0, 0), 0, 32'h0);
        dev_ready = 1'b0;
        start(48, 1);
        repeat (15) @(negedge clk);
        chk("R7 held for ready", 32'(busy), 1);
        chk("R11 lock during descriptor", 32'(dev_lock), 1);
        sema_we = 1'b1; sema_inc = 8'd2;
        @(negedge clk); sema_we = 1'b0;
        chk("R8 add while busy", 32'(sema_cnt), 3);
        dev_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 completes after ready", 32'(busy), 0);
        chk("R8 decrement after add", 32'(sema_cnt), 2);
        chk("R11 lock dropped", 32'(dev_lock), 0);

        // R7: wait for end of transfer, no lock requested
        put_desc(48, 0, mk_cmd(0, 0, 1, 0, 0, 0, 0, 0, 0), 0, 32'h0);
        dev_end = 1'b0;
        start(48, 1);
        repeat (15) @(negedge clk);
        chk("R7 held for end", 32'(busy), 1);
        chk("R11 no lock without bit", 32'(dev_lock), 0);
        dev_end = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 completes after end", 32'(busy), 0);
        chk("R8 no decrement without bit", 32'(sema_cnt), 3);

        // R12: channel reset while held
        put_desc(48, 0, mk_cmd(0, 0, 0, 1, 1, 1, 0, 0, 0), 0, 32'h0);
        dev_ready = 1'b0;
        start(48, 1);
        repeat (6) @(negedge clk);
        chk("R12 busy before reset", 32'(busy), 1);
        chan_rst = 1'b1;
        @(negedge clk); chan_rst = 1'b0;
        chk("R12 idle", 32'(busy), 0);
        chk("R12 semaphore cleared", 32'(sema_cnt), 0);
        chk("R12 lock dropped", 32'(dev_lock), 0);
        dev_ready = 1'b1;

        // R9: chain stops when semaphore runs out
        put_desc(16, 32, mk_cmd(0, 1, 0, 1, 0, 0, 0, 1, 0), 0, 32'h1111_0000);
        put_desc(32, 48, mk_cmd(0, 1, 0, 1, 0, 0, 0, 1, 0), 0, 32'h2222_0000);
        put_desc(48, 0, mk_cmd(0, 1, 0, 0, 0, 0, 1, 0, 0), 0, 32'h3333_0000);
        mclr();
        start(16, 2);
        wait_idle("R9 chain");
        chk("R9 two descriptors run", 32'(pio_n), 2);
        chk("R9 first word", pio_log[0], 32'h1111_0000);
        chk("R9 second word", pio_log[1], 32'h2222_0000);
        chk("R9 third not run", 32'(cmplt_irq), 0);
        chk("R9 semaphore empty", 32'(sema_cnt), 0);

        // R9: chain stops at a descriptor without the chain bit
        mclr();
        start(16, 5);
        wait_idle("R9 chain end");
        chk("R9 three descriptors run", 32'(pio_n), 3);
        chk("R9 third word", pio_log[2], 32'h3333_0000);
        chk("R9 semaphore left", 32'(sema_cnt), 3);
        chk("R10 flag from last", 32'(cmplt_irq), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule